// File: doc/BRIEF.md
# Strobe-Bus Host Port for a Display Controller

This block is the host-facing front end of a display controller that is driven over an 8080-style strobe bus: active-low chip select, active-low write and read strobes, a register-select line and an 18-bit data bus. The strobes are brought into the system clock through two-flop synchronisers. Every action happens on the rising edge of a strobe. A write with register select low loads the 16-bit index register. A write with register select high is steered into the write-data register and handed to the internal register/RAM port as a single-cycle write request. A read with register select high returns the contents of the read-data register and then fetches the next word into it.

A 3-bit mode input sets how many bus beats make up one word. Pixel words are 18 bits wide and instruction words are 16 bits wide. A pixel write is any data write while the index register holds the `PIXEL_INDEX` parameter value. A beat-sequencing state machine does the packing. Its states are ST_FIRST, ST_SECOND and ST_THIRD. It uses these transitions:
- advance: ST_FIRST to ST_SECOND, or ST_SECOND to ST_THIRD, on a beat that does not complete a word.
- complete: any state to ST_FIRST on the last beat of a word.
- restart: a beat whose register-select value differs from the partial word counts as the first beat of a new word.
- abort: any state to ST_FIRST while chip select is high.

Top module: `host_strobe_port`

## Requirements
- R1: A write with rs=0 loads the index register and raises no write request. In modes 000 and 010 the index is {db[17:10], db[8:1]}. In modes 001 and 011 it is two beats on db[17:10], high byte first. The index appears on req_idx 3 cycles after the last strobe release.
- R2: A write with rs=1 to a non-pixel index produces a 16-bit instruction word, placed on req_wdata as {2'b00, word}. The bit layout per mode is the same as for R1. req_wr is high for exactly the 3rd cycle after the final write-strobe release, so back-to-back instruction writes need no waits.
- R3: In mode 000 a pixel is db[17:0] in one beat. In mode 010 a pixel is the 16-bit word {db[17:10], db[8:1]} in one beat, widened to 18 bits as {w[15:11], w[15], w[10:5], w[4:0], w[4]}.
- R4: In mode 001 a pixel is two 9-bit beats on db[17:9], first beat in bits 17:9 of the pixel.
- R5: In mode 011 with pix3=0 a pixel is two bytes on db[17:10], high byte first, widened as in R3. With pix3=1 it is three 6-bit beats on db[17:12], first beat highest.
- R6: While rs=1, rd_n=0 and cs_n=0, db_oe is 1 and db_out shows the read-data register. Releasing the read strobe raises req_rd for one cycle. The word on rd_data_in in that cycle is captured, and the next read returns it.
- R7: The read-data register clears to 0 on every index write. The first read after an index write therefore returns 0, and valid data comes from the second read onward.
- R8: A read strobe with rs=0 is ignored: db_oe stays 0, no req_rd is issued, and the read-data register keeps its value.
- R9: While cs_n=1 no strobe has any effect. Raising cs_n discards a partly assembled word.
- R10: A beat whose rs differs from the partial word's rs starts a new word. An index write therefore discards a partial pixel.
- R11: Modes 100 to 111 ignore all writes.
- R12: req_wr and req_rd each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Bus width mode (000, 001, 010, 011) |
| pix3 | input | 1 | Mode 011: three 6-bit beats per pixel |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rs | input | 1 | Register select: 0 index, 1 data |
| db_in | input | 18 | Bus data from host |
| db_out | output | 18 | Bus data to host (read-data register) |
| db_oe | output | 1 | Bus output enable |
| req_wr | output | 1 | Write request to register/RAM port |
| req_rd | output | 1 | Read request to register/RAM port |
| req_idx | output | 16 | Index register |
| req_wdata | output | 18 | Write-data register |
| rd_data_in | input | 18 | Read data returned by the internal port in the req_rd cycle |

## Verification
Each strobe release passes through two synchroniser flops and one output register. Its effect is therefore due on the third falling clock edge after the bench raises the strobe. The bench samples req_wr at the first, second, third and fourth falling edges, expecting it high only at the third. Every other write or read holds its strobe low for three cycles and then idles for five, so all results have settled before they are read. A falling-edge monitor counts request pulses and records their data. The read value is taken while the strobe is still low, because db_out is valid from the register contents during that window.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_THIRD  = 2'd2
    } beat_st_e;

    localparam logic [2:0] MODE_W18 = 3'b000;
    localparam logic [2:0] MODE_W9  = 3'b001;
    localparam logic [2:0] MODE_W16 = 3'b010;
    localparam logic [2:0] MODE_W8  = 3'b011;

    // 5-6-5 word to 18-bit pixel, red and blue LSBs copy their MSBs
    function automatic logic [17:0] widen565(input logic [15:0] w);
        return {w[15:11], w[15], w[10:5], w[4:0], w[4]};
    endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] sync_n,
    output logic [W-1:0] rise
);
    logic [W-1:0] stage [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stage[i] <= '1;
        end else begin
            stage[0] <= pin_n;
            for (int i = 1; i <= STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign sync_n = stage[STAGES-1];
    assign rise   = stage[STAGES-1] & ~stage[STAGES];
endmodule

// File: rtl/beat_fsm.sv
module beat_fsm
    import host_port_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rise,
    input  logic              cs_act,
    input  logic              rs,
    input  logic [DATA_W-1:0] db,
    input  logic [2:0]        mode,
    input  logic              pix3,
    input  logic              pixel_sel,
    output logic              done,
    output logic [DATA_W-1:0] word
);
    beat_st_e    state, next_state;
    logic [8:0]  b0;
    logic [5:0]  b1;
    logic        held_rs;
    logic [1:0]  need, pos;
    logic        fire, restart, is_pix, store0, store1;
    logic [15:0] w_wide, w_pair;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_FIRST;
            b0      <= '0;
            b1      <= '0;
            held_rs <= 1'b0;
        end else begin
            state <= next_state;
            if (store0) begin
                b0      <= db[17:9];
                held_rs <= rs;
            end
            if (store1) b1 <= db[17:12];
        end
    end

    always_comb begin
        is_pix = rs && pixel_sel;
        unique case (mode)
            MODE_W18, MODE_W16: need = 2'd1;
            MODE_W9:            need = 2'd2;
            MODE_W8:            need = (is_pix && pix3) ? 2'd3 : 2'd2;
            default:            need = 2'd0;
        endcase
        restart    = (state != ST_FIRST) && (rs != held_rs);
        pos        = restart ? 2'd0 : state;
        fire       = wr_rise && cs_act && (need != 2'd0);
        done       = fire && (pos + 2'd1 == need);
        store0     = fire && !done && (pos == 2'd0);
        store1     = fire && !done && (pos == 2'd1);
        next_state = state;
        if (!cs_act)        next_state = ST_FIRST;
        else if (done)      next_state = ST_FIRST;
        else if (store0)    next_state = ST_SECOND;
        else if (store1)    next_state = ST_THIRD;

        w_wide = {db[17:10], db[8:1]};
        w_pair = {b0[8:1], db[17:10]};
        unique case (need)
            2'd1:    word = is_pix ? ((mode == MODE_W18) ? db : widen565(w_wide))
                                   : {2'b00, w_wide};
            2'd2:    word = !is_pix ? {2'b00, w_pair}
                          : ((mode == MODE_W9) ? {b0, db[17:9]} : widen565(w_pair));
            2'd3:    word = {b0[8:3], b1, db[17:12]};
            default: word = '0;
        endcase
    end

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> state == ST_FIRST);  // R9
    AST_THIRD_ONLY_W8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THIRD && $past(state) != ST_THIRD) |-> $past(mode) == MODE_W8);  // R5
endmodule

// File: rtl/host_strobe_port.sv
module host_strobe_port
    import host_port_pkg::*;
#(
    parameter int          DATA_W      = 18,
    parameter int          IDX_W       = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] PIXEL_INDEX = 16'h0202
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              pix3,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rs,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              req_wr,
    output logic              req_rd,
    output logic [IDX_W-1:0]  req_idx,
    output logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] rd_data_in
);
    logic [2:0]        sync_n, rise;
    logic              cs_act, wr_rise, rd_rise, done;
    logic [DATA_W-1:0] word, rdr, wdr;
    logic [IDX_W-1:0]  idx;

    strobe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n({cs_n, wr_n, rd_n}),
        .sync_n(sync_n), .rise(rise)
    );

    assign cs_act  = ~sync_n[2];
    assign wr_rise = rise[1];
    assign rd_rise = rise[0];

    beat_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .cs_act(cs_act),
        .rs(rs), .db(db_in), .mode(mode), .pix3(pix3),
        .pixel_sel(idx == PIXEL_INDEX), .done(done), .word(word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            wdr    <= '0;
            rdr    <= '0;
            req_wr <= 1'b0;
            req_rd <= 1'b0;
        end else begin
            req_wr <= 1'b0;
            req_rd <= 1'b0;
            if (req_rd) rdr <= rd_data_in;
            if (done) begin
                if (!rs) begin
                    idx <= word[IDX_W-1:0];
                    rdr <= '0;
                end else begin
                    wdr    <= word;
                    req_wr <= 1'b1;
                end
            end
            if (rd_rise && cs_act && rs) req_rd <= 1'b1;
        end
    end

    assign req_idx   = idx;
    assign req_wdata = wdr;
    assign db_out    = rdr;
    assign db_oe     = ~cs_n & ~rd_n & wr_n & rs;

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_wr, req_rd}));  // R12
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> !req_wr);  // R12
    AST_CS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !req_wr && !req_rd);  // R9
    AST_RD_NEEDS_RS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_rd) |-> $past(rs));  // R8
    AST_IDX_CLEARS_RDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rs && !req_rd) |=> db_out == '0);  // R7
endmodule

// File: tb/host_strobe_port_bench.sv
module host_strobe_port_bench;
    localparam logic [15:0] PIX = 16'h0202;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        pix3 = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, rs = 1'b0;
    logic [17:0] db_in = '0;
    logic [17:0] db_out, req_wdata, rd_data_in;
    logic        db_oe, req_wr, req_rd;
    logic [15:0] req_idx;

    int errors = 0, checks = 0;
    int wr_cnt = 0, rd_cnt = 0, bad_pulse = 0;
    logic [17:0] last_wdata = '0;
    logic        prev_wr = 1'b0;
    logic [7:0]  rcnt;

    always #5 clk = ~clk;

    host_strobe_port u_host_strobe_port (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pix3(pix3), .cs_n(cs_n),
        .wr_n(wr_n), .rd_n(rd_n), .rs(rs), .db_in(db_in), .db_out(db_out),
        .db_oe(db_oe), .req_wr(req_wr), .req_rd(req_rd), .req_idx(req_idx),
        .req_wdata(req_wdata), .rd_data_in(rd_data_in)
    );

    // internal port model: k-th fetch returns 0x15000 + k
    always @(posedge clk or negedge rst_n)
        if (!rst_n) rcnt <= '0;
        else if (req_rd) rcnt <= rcnt + 8'd1;
    assign rd_data_in = 18'h15000 + {10'b0, rcnt};

    always @(negedge clk) begin
        if (req_wr) begin wr_cnt++; last_wdata = req_wdata; end
        if (req_rd) rd_cnt++;
        if ((req_wr && prev_wr) || (req_wr && req_rd)) bad_pulse++;
        prev_wr = req_wr;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic c, input logic r, input logic [17:0] d);
        @(negedge clk);
        cs_n = c; rs = r; db_in = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic word16(input logic r, input logic [15:0] w);
        if (mode == 3'b000 || mode == 3'b010)
            beat(1'b0, r, {w[15:8], 1'b0, w[7:0], 1'b0});
        else begin
            beat(1'b0, r, {w[15:8], 10'b0});
            beat(1'b0, r, {w[7:0], 10'b0});
        end
    endtask

    task automatic rdbeat(input logic r, output logic [17:0] got, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rs = r; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        got = db_out; oe = db_oe;
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  m;
        logic        p3;
        logic [1:0]  nb;
        logic [17:0] b0, b1, b2, exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'b000, 1'b0, 2'd1, 18'h2B3C5, 18'h0,     18'h0,     18'h2B3C5},  // R3
        '{3'b010, 1'b0, 2'd1, 18'h3E03E, 18'h0,     18'h0,     18'h3F03F},  // R3
        '{3'b010, 1'b0, 2'd1, 18'h21042, 18'h0,     18'h0,     18'h21842},  // R3
        '{3'b001, 1'b0, 2'd2, 18'h34A00, 18'h18600, 18'h0,     18'h34AC3},  // R4
        '{3'b011, 1'b0, 2'd2, 18'h01C00, 18'h38000, 18'h0,     18'h00FC0},  // R5
        '{3'b011, 1'b1, 2'd3, 18'h2A000, 18'h15000, 18'h3F000, 18'h2A57F}   // R5
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [17:0] got;
        logic        oe;
        int          w0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset req_wr", {31'b0, req_wr}, 0);
        chk("reset req_rd", {31'b0, req_rd}, 0);
        chk("reset idx", {16'b0, req_idx}, 0);
        chk("reset db_oe", {31'b0, db_oe}, 0);

        // vector table: pixel packing per mode
        for (int i = 0; i < 6; i++) begin
            mode = VECS[i].m; pix3 = VECS[i].p3;
            word16(1'b0, PIX);
            w0 = wr_cnt;
            beat(1'b0, 1'b1, VECS[i].b0);
            if (VECS[i].nb > 2'd1) beat(1'b0, 1'b1, VECS[i].b1);
            if (VECS[i].nb > 2'd2) beat(1'b0, 1'b1, VECS[i].b2);
            chk($sformatf("R3/R4/R5 vec%0d count", i), wr_cnt - w0, 1);
            chk($sformatf("R3/R4/R5 vec%0d pixel", i), {14'b0, last_wdata}, {14'b0, VECS[i].exp});
        end

        // R1: index writes, no write request
        mode = 3'b000; pix3 = 1'b0;
        w0 = wr_cnt;
        word16(1'b0, 16'h1234);
        chk("R1 idx wide", {16'b0, req_idx}, 32'h1234);
        mode = 3'b011;
        word16(1'b0, 16'h5678);
        chk("R1 idx bytes", {16'b0, req_idx}, 32'h5678);
        chk("R1 no req_wr", wr_cnt - w0, 0);

        // R2: instruction write with exact timing
        mode = 3'b000;
        word16(1'b0, 16'h0007);
        @(negedge clk);
        cs_n = 1'b0; rs = 1'b1; db_in = {8'hAB, 1'b0, 8'hCD, 1'b0}; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk); chk("R2 edge1", {31'b0, req_wr}, 0);
        @(negedge clk); chk("R2 edge2", {31'b0, req_wr}, 0);
        @(negedge clk); chk("R2 edge3", {31'b0, req_wr}, 1);
        chk("R2 data", {14'b0, req_wdata}, 32'h0ABCD);
        @(negedge clk); chk("R2 edge4", {31'b0, req_wr}, 0);
        repeat (3) @(negedge clk);
        mode = 3'b001;
        word16(1'b1, 16'h1234);
        chk("R2 byte instr", {14'b0, last_wdata}, 32'h01234);

        // R6/R7: reads
        mode = 3'b000;
        word16(1'b0, PIX);
        r0 = rd_cnt;
        rdbeat(1'b1, got, oe);
        chk("R7 first read", {14'b0, got}, 0);
        chk("R6 oe", {31'b0, oe}, 1);
        chk("R6 req_rd", rd_cnt - r0, 1);
        rdbeat(1'b1, got, oe);
        chk("R6 second read", {14'b0, got}, 32'h15000);
        rdbeat(1'b1, got, oe);
        chk("R6 third read", {14'b0, got}, 32'h15001);

        // R8: read with rs=0 ignored
        r0 = rd_cnt;
        rdbeat(1'b0, got, oe);
        chk("R8 oe low", {31'b0, oe}, 0);
        chk("R8 no req_rd", rd_cnt - r0, 0);
        rdbeat(1'b1, got, oe);
        chk("R8 rdr kept", {14'b0, got}, 32'h15002);
        word16(1'b0, PIX);
        rdbeat(1'b1, got, oe);
        chk("R7 cleared", {14'b0, got}, 0);

        // R9: chip select blocks and aborts
        mode = 3'b011; pix3 = 1'b1;
        word16(1'b0, PIX);
        w0 = wr_cnt;
        beat(1'b0, 1'b1, 18'h11000);
        @(negedge clk); cs_n = 1'b1;
        repeat (6) @(negedge clk);
        beat(1'b1, 1'b1, 18'h3F000);
        beat(1'b1, 1'b0, 18'h3F000);
        chk("R9 blocked", wr_cnt - w0, 0);
        chk("R9 idx held", {16'b0, req_idx}, {16'b0, PIX});
        beat(1'b0, 1'b1, 18'h2A000);
        beat(1'b0, 1'b1, 18'h15000);
        beat(1'b0, 1'b1, 18'h3F000);
        chk("R9 one word", wr_cnt - w0, 1);
        chk("R9 pixel", {14'b0, last_wdata}, 32'h2A57F);

        // R10: index write discards partial pixel
        pix3 = 1'b0;
        w0 = wr_cnt;
        beat(1'b0, 1'b1, 18'h01C00);
        word16(1'b0, PIX);
        chk("R10 idx", {16'b0, req_idx}, {16'b0, PIX});
        chk("R10 no write", wr_cnt - w0, 0);
        beat(1'b0, 1'b1, 18'h01C00);
        beat(1'b0, 1'b1, 18'h38000);
        chk("R10 count", wr_cnt - w0, 1);
        chk("R10 pixel", {14'b0, last_wdata}, 32'h00FC0);

        // R11: reserved modes ignore writes
        mode = 3'b100;
        w0 = wr_cnt;
        beat(1'b0, 1'b1, 18'h3FFFF);
        beat(1'b0, 1'b0, 18'h3FFFF);
        chk("R11 no write", wr_cnt - w0, 0);
        chk("R11 idx held", {16'b0, req_idx}, {16'b0, PIX});

        // R12: pulse shape over whole run
        chk("R12 pulses", bad_pulse, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule